// File: doc/BRIEF.md
# Multi-function I/O register file

This block is a sixteen-entry byte-wide register map that sits behind a simple synchronous bus slave. A host writes and reads 8-bit registers at 4-bit addresses. Through them it loads two 12-bit analog output codes, drives and samples an 8-bit digital port, sets two PWM duty bytes, an enable byte and a timer divider byte, starts an external analog-to-digital conversion and reads its result, and takes snapshots of two external event counters.

The analog output codes are double-buffered. A low-byte write is held internally. The output changes only when the high nibble is written, so a 12-bit code never appears half-updated. The codes are offset binary: the host flips the sign bit of a two's-complement value, so code 0x800 is mid-scale.

Counter values are never read live. A latch command copies one counter into a 16-bit snapshot, which is then read one byte at a time. PWM generation, the counters and the converters are outside this block. Only their register interface is here.

Top module: `mfio_regfile`

## Requirements
- R1: While `rst` is high, and after it is released, every output is zero until a write or read changes it: codes, digital out, duty, enable, timer, ADC control, pulses and `rdata`.
- R2: A write to address 4 (or 6) loads only a holding byte and leaves the channel's code unchanged. A write to address 5 (or 7) sets the code to {wdata[3:0], holding byte} in the cycle after the write. wdata[7:4] is ignored.
- R3: Channel 0 (addresses 4/5) and channel 1 (addresses 6/7) are independent: a write to one leaves the other's code unchanged.
- R4: A write to address 8 sets `dout`. A read of address 8 returns `din`.
- R5: A write to address 2 stores the byte on `adc_ctrl` and raises `adc_start` for exactly one cycle, the cycle after the write. The byte fields are channel bits 2:0, bipolar bit 3, range bit 4, acquisition bit 5 and power bits 7:6.
- R6: A read of address 2 returns `adc_busy` in bit 0, so it reads 1 while a conversion runs, and returns 0 in bits 7:1.
- R7: A read of address 0 returns `adc_result[7:0]`. A read of address 1 returns {4'b0, `adc_result[11:8]`}.
- R8: Writes to addresses 9, 10, 11 and 12 set `pwm0_duty`, `pwm1_duty`, `enables` and `timer_div` respectively. In `enables`, bit 7 is the buzzer, bits 6:4 are counters 3..1 and bits 3:0 are PWM 4..1.
- R9: A write to address 13 acts on its bits as one-shot commands. Bit 2 latches counter 1 and bit 3 latches counter 2; if both are set, counter 1 wins. Bit 0 raises `cnt1_clr` and bit 1 raises `cnt2_clr`, each for one cycle.
- R10: Address 14 returns the snapshot's low byte and address 15 its high byte. The snapshot holds its value while the counters change, until the next latch command.
- R11: Reads of address 3 and of the write-only addresses 4–7 and 9–13 return zero.
- R12: `rdata` is registered. It shows the addressed value in the cycle after `rd_en` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| dac0_code | output | 12 | Analog output code, channel 0 |
| dac1_code | output | 12 | Analog output code, channel 1 |
| dout | output | 8 | Digital outputs |
| din | input | 8 | Digital inputs |
| pwm0_duty | output | 8 | Duty byte, PWM 0 |
| pwm1_duty | output | 8 | Duty byte, PWM 1 |
| enables | output | 8 | Peripheral enable byte |
| timer_div | output | 8 | Timer divider byte |
| adc_ctrl | output | 8 | Last ADC control byte |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_busy | input | 1 | Conversion in progress |
| adc_result | input | 12 | Conversion result |
| cnt1_val | input | 16 | Counter 1 value |
| cnt2_val | input | 16 | Counter 2 value |
| cnt1_clr | output | 1 | One-cycle clear pulse, counter 1 |
| cnt2_clr | output | 1 | One-cycle clear pulse, counter 2 |

## Verification
Most register faults show up the cycle after the offending write. This covers a wrong holding byte, a code that tears on a low-byte write, and a pulse that sticks or repeats. Each of these is checked directly on the output ports at that point.

A wrong snapshot stays hidden until addresses 14 or 15 are read. The bench therefore reads it again after the counters move and after a double latch command, to catch a live value leaking through or the wrong priority.

Read-path faults show up one cycle after `rd_en`. A scoreboard compares every read in order against values derived from the requirements.

// File: rtl/mfio_pkg.sv
package mfio_pkg;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] A_ADC_LO  = 4'd0;
  localparam logic [AW-1:0] A_ADC_HI  = 4'd1;
  localparam logic [AW-1:0] A_ADC_CS  = 4'd2;
  localparam logic [AW-1:0] A_RSVD    = 4'd3;
  localparam logic [AW-1:0] A_DAC0_LO = 4'd4;
  localparam logic [AW-1:0] A_DAC0_HI = 4'd5;
  localparam logic [AW-1:0] A_DAC1_LO = 4'd6;
  localparam logic [AW-1:0] A_DAC1_HI = 4'd7;
  localparam logic [AW-1:0] A_DIGIO   = 4'd8;
  localparam logic [AW-1:0] A_PWM0    = 4'd9;
  localparam logic [AW-1:0] A_PWM1    = 4'd10;
  localparam logic [AW-1:0] A_ENAB    = 4'd11;
  localparam logic [AW-1:0] A_TIMER   = 4'd12;
  localparam logic [AW-1:0] A_CNTCMD  = 4'd13;
  localparam logic [AW-1:0] A_SNAP_LO = 4'd14;
  localparam logic [AW-1:0] A_SNAP_HI = 4'd15;
  // command bit positions in the counter control byte
  localparam int B_CLR1 = 0;
  localparam int B_CLR2 = 1;
  localparam int B_LAT1 = 2;
  localparam int B_LAT2 = 3;
endpackage

// File: rtl/mfio_dac_chan.sv
module mfio_dac_chan #(
  parameter int CODE_W = 12,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DW-1:0]     wdata,
  output logic [CODE_W-1:0] code
);
  localparam int HI_W = CODE_W - DW;
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      code   <= '0;
    end else begin
      if (ld_lo) hold_q <= wdata;
      if (ld_hi) code <= {wdata[HI_W-1:0], hold_q};
    end
  end

  // R2: without a high-byte load the code stays put
  assert_dac_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ld_hi |=> $stable(code));
  // R2: a low-byte load never reaches the code in the next cycle
  assert_dac_lo_only_R2: assert property (@(posedge clk) disable iff (rst)
    (ld_lo && !ld_hi) |=> $stable(code));
endmodule

// File: rtl/mfio_cnt_snap.sv
module mfio_cnt_snap
  import mfio_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cnt1,
  input  logic [CW-1:0] cnt2,
  output logic [CW-1:0] snap,
  output logic          clr1,
  output logic          clr2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
      clr1 <= 1'b0;
      clr2 <= 1'b0;
    end else begin
      clr1 <= cmd_wr && wdata[B_CLR1];
      clr2 <= cmd_wr && wdata[B_CLR2];
      if (cmd_wr && wdata[B_LAT1])      snap <= cnt1;
      else if (cmd_wr && wdata[B_LAT2]) snap <= cnt2;
    end
  end

  // R10: snapshot only moves on a latch command
  assert_snap_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !(cmd_wr && (wdata[B_LAT1] || wdata[B_LAT2])) |=> $stable(snap));
  // R9: clear pulses only follow a command write
  assert_clr1_src_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(clr1) |-> $past(cmd_wr));
  assert_clr2_src_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(clr2) |-> $past(cmd_wr));
endmodule

// File: rtl/mfio_rd_mux.sv
module mfio_rd_mux
  import mfio_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CW    = 16
) (
  input  logic [AW-1:0]    addr,
  input  logic [RES_W-1:0] adc_result,
  input  logic             adc_busy,
  input  logic [DW-1:0]    din,
  input  logic [CW-1:0]    snap,
  output logic [DW-1:0]    dout
);
  localparam int PAD = 2 * DW;
  logic [PAD-1:0] res_p, snap_p;

  always_comb begin
    res_p  = PAD'(adc_result);
    snap_p = PAD'(snap);
    unique case (addr)
      A_ADC_LO:  dout = res_p[DW-1:0];
      A_ADC_HI:  dout = res_p[PAD-1:DW];
      A_ADC_CS:  dout = {{(DW-1){1'b0}}, adc_busy};
      A_DIGIO:   dout = din;
      A_SNAP_LO: dout = snap_p[DW-1:0];
      A_SNAP_HI: dout = snap_p[PAD-1:DW];
      default:   dout = '0;
    endcase
  end
endmodule

// File: rtl/mfio_regfile.sv
module mfio_regfile
  import mfio_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int RES_W  = 12,
  parameter int CW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [CODE_W-1:0] dac0_code,
  output logic [CODE_W-1:0] dac1_code,
  output logic [7:0]        dout,
  input  logic [7:0]        din,
  output logic [7:0]        pwm0_duty,
  output logic [7:0]        pwm1_duty,
  output logic [7:0]        enables,
  output logic [7:0]        timer_div,
  output logic [7:0]        adc_ctrl,
  output logic              adc_start,
  input  logic              adc_busy,
  input  logic [RES_W-1:0]  adc_result,
  input  logic [CW-1:0]     cnt1_val,
  input  logic [CW-1:0]     cnt2_val,
  output logic              cnt1_clr,
  output logic              cnt2_clr
);
  localparam int NCH = 2;

  logic [CODE_W-1:0] codes [NCH];
  logic [CW-1:0]     snap;
  logic [DW-1:0]     mux_q;

  function automatic logic hit(input logic [AW-1:0] a);
    return wr_en && (addr == a);
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_dac
    localparam logic [AW-1:0] LO_A = A_DAC0_LO + AW'(2 * c);
    mfio_dac_chan #(.CODE_W(CODE_W), .DW(DW)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .ld_lo (hit(LO_A)),
      .ld_hi (hit(LO_A + 4'd1)),
      .wdata (wdata),
      .code  (codes[c])
    );
  end
  assign dac0_code = codes[0];
  assign dac1_code = codes[1];

  mfio_cnt_snap #(.CW(CW)) u_snap (
    .clk    (clk),
    .rst    (rst),
    .cmd_wr (hit(A_CNTCMD)),
    .wdata  (wdata),
    .cnt1   (cnt1_val),
    .cnt2   (cnt2_val),
    .snap   (snap),
    .clr1   (cnt1_clr),
    .clr2   (cnt2_clr)
  );

  mfio_rd_mux #(.RES_W(RES_W), .CW(CW)) u_mux (
    .addr       (addr),
    .adc_result (adc_result),
    .adc_busy   (adc_busy),
    .din        (din),
    .snap       (snap),
    .dout       (mux_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout      <= '0;
      pwm0_duty <= '0;
      pwm1_duty <= '0;
      enables   <= '0;
      timer_div <= '0;
      adc_ctrl  <= '0;
      adc_start <= 1'b0;
      rdata     <= '0;
    end else begin
      adc_start <= hit(A_ADC_CS);
      if (hit(A_ADC_CS)) adc_ctrl  <= wdata;
      if (hit(A_DIGIO))  dout      <= wdata;
      if (hit(A_PWM0))   pwm0_duty <= wdata;
      if (hit(A_PWM1))   pwm1_duty <= wdata;
      if (hit(A_ENAB))   enables   <= wdata;
      if (hit(A_TIMER))  timer_div <= wdata;
      if (rd_en)         rdata     <= mux_q;
    end
  end

  // R5: start pulse is a single cycle following a control write
  assert_start_src_R5: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> $past(wr_en && addr == A_ADC_CS));
  // R3: a write to channel 1 leaves channel 0 alone
  assert_chan_indep_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DAC1_HI) |=> $stable(dac0_code));
  // R11: the reserved address reads as zero
  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_RSVD) |=> rdata == 8'h00);
  // R12: read data only changes after a read strobe
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  // R1: reset clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dac0_code == '0 && dout == '0 && !adc_start && rdata == '0));
endmodule

// File: tb/mfio_regfile_test.sv
module mfio_regfile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [11:0] dac0_code, dac1_code;
  logic [7:0]  dout, din = '0;
  logic [7:0]  pwm0_duty, pwm1_duty, enables, timer_div, adc_ctrl;
  logic        adc_start, adc_busy = 1'b0;
  logic [11:0] adc_result = '0;
  logic [15:0] cnt1_val = '0, cnt2_val = '0;
  logic        cnt1_clr, cnt2_clr;

  int n_tests = 0, n_fail = 0;
  logic pend = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  mfio_regfile uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dac0_code(dac0_code), .dac1_code(dac1_code),
    .dout(dout), .din(din), .pwm0_duty(pwm0_duty), .pwm1_duty(pwm1_duty),
    .enables(enables), .timer_div(timer_div), .adc_ctrl(adc_ctrl),
    .adc_start(adc_start), .adc_busy(adc_busy), .adc_result(adc_result),
    .cnt1_val(cnt1_val), .cnt2_val(cnt2_val), .cnt1_clr(cnt1_clr),
    .cnt2_clr(cnt2_clr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: push expected read value into the scoreboard
  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) pend <= rd_en;

  // monitor: compare registered read data one cycle after the strobe
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check("R12 unexpected read", 32'd1, 32'd0);
      else check(tag_q.pop_front(), {24'd0, rdata}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic finish_run;
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R12 reads left pending", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    check("watchdog expired", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 dac0", dac0_code, 0);
    check("R1 dout", dout, 0);
    check("R1 adc_start", adc_start, 0);
    check("R1 rdata", rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 enables after release", enables, 0);

    // R2: low byte held, high write applies both parts
    wr(4'd4, 8'h34);
    check("R2 low write holds code", dac0_code, 0);
    wr(4'd5, 8'hA7);
    check("R2 high write update", dac0_code, 12'h734);
    wr(4'd4, 8'hFF);
    check("R2 later low write ignored", dac0_code, 12'h734);
    // R3: channel 1 mid-scale, channel 0 untouched
    wr(4'd7, 8'h08);
    check("R3 dac1 mid-scale", dac1_code, 12'h800);
    check("R3 dac0 unchanged", dac0_code, 12'h734);
    wr(4'd5, 8'h01);
    check("R3 dac0 uses new hold", dac0_code, 12'h1FF);
    check("R3 dac1 unchanged", dac1_code, 12'h800);

    // R4 digital I/O
    wr(4'd8, 8'h5A);
    check("R4 dout", dout, 8'h5A);
    din = 8'hC3;
    rd(4'd8, 8'hC3, "R4 read din");

    // R5 start pulse
    wr(4'd2, 8'h5B);
    check("R5 start pulse", adc_start, 1);
    check("R5 ctrl byte", adc_ctrl, 8'h5B);
    @(negedge clk);
    check("R5 pulse ends", adc_start, 0);
    // R6 status
    adc_busy = 1'b1;
    rd(4'd2, 8'h01, "R6 busy");
    adc_busy = 1'b0;
    rd(4'd2, 8'h00, "R6 done");
    // R7 result
    adc_result = 12'hABC;
    rd(4'd0, 8'hBC, "R7 low");
    rd(4'd1, 8'h0A, "R7 high");

    // R8
    wr(4'd9, 8'h11);  check("R8 pwm0", pwm0_duty, 8'h11);
    wr(4'd10, 8'h22); check("R8 pwm1", pwm1_duty, 8'h22);
    wr(4'd11, 8'h81); check("R8 enables", enables, 8'h81);
    wr(4'd12, 8'h7E); check("R8 timer", timer_div, 8'h7E);

    // R9 / R10 counters
    cnt1_val = 16'h1234; cnt2_val = 16'hBEEF;
    wr(4'd13, 8'h04);
    check("R9 no clr on latch", {cnt1_clr, cnt2_clr}, 0);
    rd(4'd14, 8'h34, "R10 snap low");
    rd(4'd15, 8'h12, "R10 snap high");
    cnt1_val = 16'h5555;
    rd(4'd14, 8'h34, "R10 snap holds");
    wr(4'd13, 8'h08);
    rd(4'd15, 8'hBE, "R9 latch cnt2");
    wr(4'd13, 8'h0C);
    rd(4'd14, 8'h55, "R9 cnt1 priority");
    wr(4'd13, 8'h03);
    check("R9 clr1", cnt1_clr, 1);
    check("R9 clr2", cnt2_clr, 1);
    rd(4'd15, 8'h55, "R9 clr leaves snap");
    check("R9 clr1 ends", cnt1_clr, 0);
    wr(4'd13, 8'h02);
    check("R9 clr2 only", {cnt1_clr, cnt2_clr}, 2'b01);

    // R11 zero reads
    rd(4'd3, 8'h00, "R11 reserved");
    rd(4'd5, 8'h00, "R11 dac hi");
    rd(4'd9, 8'h00, "R11 pwm0");
    rd(4'd11, 8'h00, "R11 enables");
    rd(4'd13, 8'h00, "R11 cntcmd");

    // R12 hold between reads
    rd(4'd8, 8'hC3, "R12 read");
    din = 8'h00;
    repeat (2) @(negedge clk);
    check("R12 rdata held", rdata, 8'hC3);

    finish_run();
  end
endmodule